// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line that rests high. A line-rate enable, `sample_tick`, pulses at sixteen times the bit rate and is supplied from outside the block. Each bit cell is therefore seen as sixteen samples. A falling edge on the idle line opens a frame. Three samples taken at the centre of each cell decide the bit value by majority. The same three samples also reveal line disturbance whenever they disagree.

Frames carry a low start bit, then eight or nine data bits sent least significant first, then one high stop bit. The `nine_bit_mode` input selects the data length. A completed character is moved into a holding register that the host reads. The host also sees four status flags: receive-full, overrun, noise and framing error. The host reports its reads with two strobes, `stat_rd` and `data_rd`. A status read made while any flag is up, followed later by a data read, clears all four flags.

Top module: `uart_rx_os16`

## Requirements
- R1: A start is taken from a 1-to-0 change of the synchronised line. The start is kept only if the majority of samples 7, 8 and 9 of the start cell is 0. If that majority is 1, the receiver goes back to hunting, and no character or flag results.
- R2: Samples are counted 0 to 15 in each bit cell, and sample 0 is the first sample at the new level. Each data bit takes the majority value of samples 7, 8 and 9 of its cell. The first data bit received lands in `rx_data[0]`.
- R3: With `nine_bit_mode`=1 the receiver takes nine data bits and the ninth appears on `rx_bit8`. With `nine_bit_mode`=0 it takes eight and `rx_bit8` reads 0.
- R4: `rx_full` rises when a completed character is written into `rx_data`/`rx_bit8`.
- R5: If samples 7, 8 and 9 of any cell (start, data or stop) are not all equal, the character is still loaded and `rx_noise` is set.
- R6: If the stop-cell majority is 0, `rx_frame_err` is set and the character is still loaded.
- R7: If a character completes while `rx_full`=1, `rx_overrun` is set and the new character is dropped. `rx_data` and `rx_bit8` keep the earlier character.
- R8: A `stat_rd` pulse while any flag is 1, followed later by a `data_rd` pulse, clears `rx_full`, `rx_overrun`, `rx_noise` and `rx_frame_err`.
- R9: A `data_rd` pulse that has no armed status read before it leaves every flag unchanged.
- R10: After reset, every flag and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| nine_bit_mode | input | 1 | 1 selects nine data bits |
| stat_rd | input | 1 | One-cycle strobe: host read of status |
| data_rd | input | 1 | One-cycle strobe: host read of data |
| rx_data | output | 8 | Low eight bits of the held character |
| rx_bit8 | output | 1 | Ninth bit of the held character |
| rx_full | output | 1 | Receive-full flag |
| rx_overrun | output | 1 | Overrun flag |
| rx_noise | output | 1 | Noise flag |
| rx_frame_err | output | 1 | Framing-error flag |

## Verification
The assertions assume that `sample_tick` is never high on two clock edges in a row. They also assume that the host does not pulse `data_rd` in the same cycle that a character completes. The stimulus drives `sample_tick` on every other clock. It changes `rxd` only on falling clock edges and holds each level for exactly one tick period, so every sample falls at a known position in its cell. The bench issues host strobes only after the line has been idle for at least a full bit time, which keeps reads clear of frame completion.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic s_in,
  output logic prev,
  output logic maj,
  output logic split
);
  logic [1:0] hist;

  always_ff @(posedge clk) begin
    if (rst)       hist <= 2'b11;
    else if (tick) hist <= {hist[0], s_in};
  end

  assign prev  = hist[0];
  assign maj   = (hist[1] & hist[0]) | (hist[1] & s_in) | (hist[0] & s_in);
  assign split = ~((hist[1] == hist[0]) && (hist[0] == s_in));
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              nine,
  input  logic              s_in,
  input  logic              prev,
  input  logic              maj,
  input  logic              split,
  output logic              done,
  output logic [DATA_W:0]   word,
  output logic              nz,
  output logic              fe
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] EVAL = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t        st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [BW-1:0]    nbits;
  logic [DATA_W:0]  shreg;
  logic             nacc;

  assign nbits = nine ? BW'(DATA_W + 1) : BW'(DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_HUNT;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      nacc  <= 1'b0;
      done  <= 1'b0;
      word  <= '0;
      nz    <= 1'b0;
      fe    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == RX_HUNT) begin
          if (!s_in && prev) begin
            st   <= RX_START;
            cnt  <= CW'(1);
            nacc <= 1'b0;
          end
        end else begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == EVAL) begin
            case (st)
              RX_START: begin
                if (maj) st <= RX_HUNT;
                else begin
                  st   <= RX_DATA;
                  bitn <= '0;
                  nacc <= split;
                end
              end
              RX_DATA: begin
                shreg <= {maj, shreg[DATA_W:1]};
                nacc  <= nacc | split;
                bitn  <= bitn + 1'b1;
                if (bitn == nbits - 1'b1) st <= RX_STOP;
              end
              default: begin
                done <= 1'b1;
                word <= nine ? shreg : {1'b0, shreg[DATA_W:1]};
                nz   <= nacc | split;
                fe   <= ~maj;
                st   <= RX_HUNT;
              end
            endcase
          end
        end
      end
    end
  end

  assert_stop_count_R3: assert property (@(posedge clk) disable iff (rst)
    (st == RX_STOP) |-> (bitn == nbits));
  assert_hunt_needs_tick_R1: assert property (@(posedge clk) disable iff (rst)
    (st == RX_HUNT && !tick) |=> (st == RX_HUNT));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/rx_host_regs.sv
module rx_host_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W:0]   word,
  input  logic              nz,
  input  logic              fe,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              rx_noise,
  output logic              rx_frame_err
);
  logic armed;
  logic any_flag;
  logic clr;
  logic full_eff;

  assign any_flag = rx_full | rx_overrun | rx_noise | rx_frame_err;
  assign clr      = data_rd & armed;
  assign full_eff = rx_full & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed        <= 1'b0;
      rx_data      <= '0;
      rx_bit8      <= 1'b0;
      rx_full      <= 1'b0;
      rx_overrun   <= 1'b0;
      rx_noise     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      if (clr) begin
        armed        <= 1'b0;
        rx_full      <= 1'b0;
        rx_overrun   <= 1'b0;
        rx_noise     <= 1'b0;
        rx_frame_err <= 1'b0;
      end else if (stat_rd && any_flag) begin
        armed <= 1'b1;
      end
      if (done) begin
        if (full_eff) begin
          rx_overrun <= 1'b1;
        end else begin
          rx_data      <= word[DATA_W-1:0];
          rx_bit8      <= word[DATA_W];
          rx_full      <= 1'b1;
          rx_noise     <= nz;
          rx_frame_err <= fe;
        end
      end
    end
  end

  assert_err_implies_full_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_noise || rx_frame_err || rx_overrun) |-> rx_full);
  assert_overrun_keeps_data_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_overrun) |-> ($stable(rx_data) && $stable(rx_bit8)));
  assert_clear_sequence_R8: assert property (@(posedge clk) disable iff (rst)
    (data_rd && armed && !done) |=> (!rx_full && !rx_overrun && !rx_noise && !rx_frame_err));
  assert_unarmed_read_R9: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !armed && rx_full) |=> rx_full);
endmodule

// File: rtl/uart_rx_os16.sv
module uart_rx_os16 #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic              nine_bit_mode,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              rx_noise,
  output logic              rx_frame_err
);
  logic            line_s;
  logic            prev, maj, split;
  logic            done, nz, fe;
  logic [DATA_W:0] word;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(rxd), .d_out(line_s)
  );

  rx_vote3 u_vote (
    .clk(clk), .rst(rst), .tick(sample_tick), .s_in(line_s),
    .prev(prev), .maj(maj), .split(split)
  );

  rx_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_frm (
    .clk(clk), .rst(rst), .tick(sample_tick), .nine(nine_bit_mode),
    .s_in(line_s), .prev(prev), .maj(maj), .split(split),
    .done(done), .word(word), .nz(nz), .fe(fe)
  );

  rx_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .done(done), .word(word), .nz(nz), .fe(fe),
    .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err)
  );

  assert_tick_sparse_R2: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick);
endmodule

// File: tb/sim_uart_rx_os16.sv
module sim_uart_rx_os16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       nine_bit_mode = 1'b0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_full, rx_overrun, rx_noise, rx_frame_err;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) sample_tick <= 1'b0;
    else     sample_tick <= ~sample_tick;
  end

  uart_rx_os16 u0 (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .rxd(rxd),
    .nine_bit_mode(nine_bit_mode), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic lvl);
    @(negedge clk) rxd = lvl;
    @(negedge clk);
  endtask

  task automatic idle(input int ticks);
    for (int i = 0; i < ticks; i++) put(1'b1);
  endtask

  task automatic send(input logic [8:0] val, input bit nine, input int fb,
                      input int fk, input logic stopv);
    int nb;
    logic lvl;
    nb = nine ? 9 : 8;
    for (int b = 0; b < nb + 2; b++) begin
      for (int k = 0; k < 16; k++) begin
        if (b == 0) lvl = 1'b0;
        else if (b == nb + 1) lvl = stopv;
        else lvl = val[b-1];
        if (b == fb && k == fk) lvl = ~lvl;
        put(lvl);
      end
    end
    idle(24);
  endtask

  task automatic pulse_stat();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic pulse_data();
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
  endtask

  task automatic clear_all();
    pulse_stat();
    pulse_data();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!rx_full && !rx_overrun && !rx_noise && !rx_frame_err, "R10 flags", 
        {rx_full, rx_overrun, rx_noise, rx_frame_err}, 0);
    chk(rx_data == 8'h00, "R10 data", rx_data, 0);
  endtask

  task automatic t_clean8();
    nine_bit_mode = 1'b0;
    send(9'h0A5, 1'b0, -1, 0, 1'b1);
    chk(rx_data == 8'hA5, "R2 data lsb first", rx_data, 8'hA5);
    chk(rx_full, "R4 full set", rx_full, 1);
    chk(!rx_bit8, "R3 bit8 zero in 8-bit", rx_bit8, 0);
    chk(!rx_noise && !rx_frame_err && !rx_overrun, "R5 clean no errors",
        {rx_overrun, rx_noise, rx_frame_err}, 0);
    clear_all();
    chk(!rx_full, "R8 clear full", rx_full, 0);
  endtask

  task automatic t_nine();
    nine_bit_mode = 1'b1;
    send(9'h13C, 1'b1, -1, 0, 1'b1);
    chk(rx_data == 8'h3C, "R3 nine data", rx_data, 8'h3C);
    chk(rx_bit8, "R3 ninth bit", rx_bit8, 1);
    clear_all();
    nine_bit_mode = 1'b0;
  endtask

  task automatic t_noise();
    send(9'h05A, 1'b0, 4, 8, 1'b1);
    chk(rx_data == 8'h5A, "R2 vote rejects glitch", rx_data, 8'h5A);
    chk(rx_noise, "R5 noise set", rx_noise, 1);
    chk(!rx_frame_err, "R5 no frame err", rx_frame_err, 0);
    clear_all();
    chk(!rx_noise && !rx_full, "R8 noise cleared", {rx_noise, rx_full}, 0);
    send(9'h0C3, 1'b0, 9, 2, 1'b1);
    chk(!rx_noise && rx_data == 8'hC3, "R5 edge sample ignored", {rx_noise, rx_data}, 8'hC3);
    clear_all();
  endtask

  task automatic t_frame();
    send(9'h066, 1'b0, -1, 0, 1'b0);
    chk(rx_frame_err, "R6 frame err", rx_frame_err, 1);
    chk(rx_full && rx_data == 8'h66, "R6 char loaded", rx_data, 8'h66);
    pulse_data();
    @(negedge clk);
    chk(rx_frame_err && rx_full, "R9 unarmed read keeps flags",
        {rx_frame_err, rx_full}, 2'b11);
    clear_all();
    chk(!rx_frame_err && !rx_full, "R8 frame cleared", {rx_frame_err, rx_full}, 0);
  endtask

  task automatic t_overrun();
    send(9'h011, 1'b0, -1, 0, 1'b1);
    send(9'h022, 1'b0, -1, 0, 1'b1);
    chk(rx_overrun, "R7 overrun set", rx_overrun, 1);
    chk(rx_data == 8'h11, "R7 old data kept", rx_data, 8'h11);
    clear_all();
    chk(!rx_overrun && !rx_full, "R8 overrun cleared", {rx_overrun, rx_full}, 0);
  endtask

  task automatic t_false_start();
    for (int i = 0; i < 4; i++) put(1'b0);
    idle(48);
    chk(!rx_full && !rx_noise && !rx_frame_err, "R1 false start ignored",
        {rx_full, rx_noise, rx_frame_err}, 0);
    send(9'h0E7, 1'b0, -1, 0, 1'b1);
    chk(rx_full && rx_data == 8'hE7, "R1 recovers after false start", rx_data, 8'hE7);
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    idle(20);
    t_clean8();
    t_nine();
    t_noise();
    t_frame();
    t_overrun();
    t_false_start();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule